// File: doc/BRIEF.md
# Indirect Pointer Fetch Unit

This block resolves the indirect addressing modes of a processor datapath. When `start` is pulsed, it captures a mode and its inputs. It then forms a 16-bit pointer address in bank zero and reads two or three pointer bytes, one after another, over a byte-wide read port that uses a request/valid handshake. From those bytes it builds one of two results: a 24-bit operand effective address, or a new program counter with an optional new program bank.

The pointer address comes from one of two places. For the jump modes, it is the two instruction address bytes used as they are. For the direct modes, it is the instruction offset byte added to the 16-bit direct register. A two-byte operand pointer takes its upper address byte from the data bank register. A three-byte pointer supplies its own bank byte. Only the long jump produces a new program bank. Instruction decode and the final operand access belong to neighbouring logic. The unit hands its result over with a single-cycle load strobe.

Top module: `ind_ptr_fetch`

## Requirements
- R1: A synchronous reset, whether applied while idle or in the middle of a fetch, returns the unit to idle. In idle, `busy_o`, `rd_req_o`, `done_o` and all three load strobes are low.
- R2: Mode 2'b00 (indirect jump) reads two bytes, with the pointer address equal to {op_hi_i, op_lo_i}. `pc_o` becomes {byte at pointer+1, byte at pointer}. `pc_load_o` pulses and `pb_load_o` stays low.
- R3: Mode 2'b01 (long indirect jump) reads the same two bytes as mode 00 and also reads a third byte at pointer+2. That third byte appears on `pb_o`, and `pb_load_o` pulses together with `pc_load_o`.
- R4: Mode 2'b10 (direct indirect) uses the pointer address dir_reg_i + op_lo_i. It reads two bytes there. `ea_o` becomes {data bank, byte at pointer+1, byte at pointer}.
- R5: Mode 2'b11 (direct indirect long) reads three bytes at dir_reg_i + op_lo_i. `ea_o` becomes {byte at pointer+2, byte at pointer+1, byte at pointer}.
- R6: The direct-register sum and the pointer+1 and pointer+2 steps all wrap modulo 2^16. Every read address has bits 23:16 equal to zero.
- R7: While `rd_req_o` is high and `rd_valid_i` is low, `rd_addr_o` holds. After each accepted byte, the address advances by one. Bytes are read in order: pointer, pointer+1, then pointer+2.
- R8: The clock edge that accepts the last pointer byte raises `done_o` for exactly one cycle. In that same cycle, exactly one of `ea_load_o` and `pc_load_o` is high. No strobe is raised at any other time.
- R9: A `start` pulse that arrives while `busy_o` is high is ignored. The running fetch finishes with its original result.
- R10: Mode, instruction bytes, direct register and data bank are all sampled at the accepted `start`. Changing them later does not alter the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a pointer fetch (accepted only when idle) |
| mode_i | input | 2 | Addressing mode: 00 jump, 01 long jump, 10 direct, 11 direct long |
| op_lo_i | input | 8 | Instruction address low byte or direct offset |
| op_hi_i | input | 8 | Instruction address high byte (jump modes) |
| dir_reg_i | input | 16 | Direct register |
| dbank_i | input | 8 | Data bank register |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | 24 | Read byte address (bank zero) |
| rd_valid_i | input | 1 | Read data valid, one byte accepted per high cycle |
| rd_data_i | input | 8 | Read data byte |
| ea_o | output | 24 | Effective address |
| ea_load_o | output | 1 | Effective address load strobe |
| pc_o | output | 16 | New program counter |
| pc_load_o | output | 1 | Program counter load strobe |
| pb_o | output | 8 | New program bank |
| pb_load_o | output | 1 | Program bank load strobe |
| done_o | output | 1 | Fetch complete, one cycle |
| busy_o | output | 1 | Fetch in progress |

## Verification
The bench builds the unit with its default byte width of 8, which gives a 16-bit pointer and a 24-bit address. At that width, short vector values reach the wrap corners: a pointer of FFFF and FFFE, and a direct-register sum that carries out of 16 bits. The bench's memory model answers with a per-vector latency of zero to two cycles. Back-to-back valid bytes and held requests are therefore both exercised. Directed runs cover a start issued while busy with every input changed, and a reset in the middle of a fetch.

// File: rtl/ipf_pkg.sv
package ipf_pkg;
    typedef enum logic [1:0] {
        IPF_JMP_IND  = 2'd0,
        IPF_JMP_LONG = 2'd1,
        IPF_DIR_IND  = 2'd2,
        IPF_DIR_LONG = 2'd3
    } ipf_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_DONE  = 2'd2
    } ipf_state_e;
endpackage

// File: rtl/ipf_ptr_base.sv
module ipf_ptr_base #(
    parameter int BYTE_W = 8,
    localparam int PTR_W = 2 * BYTE_W
) (
    input  logic              use_dir,
    input  logic [BYTE_W-1:0] op_lo,
    input  logic [BYTE_W-1:0] op_hi,
    input  logic [PTR_W-1:0]  dir_reg,
    output logic [PTR_W-1:0]  ptr
);
    // Direct modes add the offset to the direct register; the sum wraps.
    always_comb begin
        if (use_dir) ptr = dir_reg + {{BYTE_W{1'b0}}, op_lo};
        else         ptr = {op_hi, op_lo};
    end
endmodule

// File: rtl/ipf_assemble.sv
module ipf_assemble #(
    parameter int BYTE_W    = 8,
    parameter int MAX_BYTES = 3,
    localparam int PTR_W    = 2 * BYTE_W,
    localparam int EA_W     = 3 * BYTE_W
) (
    input  logic                                long_sel,
    input  logic [MAX_BYTES-1:0][BYTE_W-1:0]   bytes,
    input  logic [BYTE_W-1:0]                   bank,
    output logic [EA_W-1:0]                     ea,
    output logic [PTR_W-1:0]                    pc,
    output logic [BYTE_W-1:0]                   pb
);
    always_comb begin
        pc = {bytes[1], bytes[0]};
        pb = bytes[2];
        ea = long_sel ? {bytes[2], bytes[1], bytes[0]} : {bank, bytes[1], bytes[0]};
    end
endmodule

// File: rtl/ind_ptr_fetch.sv
module ind_ptr_fetch
    import ipf_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int PTR_W     = 2 * BYTE_W,
    localparam int EA_W      = 3 * BYTE_W,
    localparam int MAX_BYTES = 3,
    localparam int IDX_W     = $clog2(MAX_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        mode_i,
    input  logic [BYTE_W-1:0] op_lo_i,
    input  logic [BYTE_W-1:0] op_hi_i,
    input  logic [PTR_W-1:0]  dir_reg_i,
    input  logic [BYTE_W-1:0] dbank_i,
    output logic              rd_req_o,
    output logic [EA_W-1:0]   rd_addr_o,
    input  logic              rd_valid_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic [EA_W-1:0]   ea_o,
    output logic              ea_load_o,
    output logic [PTR_W-1:0]  pc_o,
    output logic              pc_load_o,
    output logic [BYTE_W-1:0] pb_o,
    output logic              pb_load_o,
    output logic              done_o,
    output logic              busy_o
);
    typedef struct packed {
        ipf_state_e                       st;
        ipf_mode_e                        mode;
        logic [PTR_W-1:0]                 ptr;
        logic [IDX_W-1:0]                 idx;
        logic [MAX_BYTES-1:0][BYTE_W-1:0] bytes;
        logic [BYTE_W-1:0]                bank;
    } regs_t;

    regs_t            r_q, r_d;
    logic [PTR_W-1:0] base_ptr;
    logic [IDX_W-1:0] last_idx;

    ipf_ptr_base #(.BYTE_W(BYTE_W)) u_base (
        .use_dir (mode_i[1]),
        .op_lo   (op_lo_i),
        .op_hi   (op_hi_i),
        .dir_reg (dir_reg_i),
        .ptr     (base_ptr)
    );

    // Long modes (bit 0 set) fetch a third byte.
    assign last_idx = r_q.mode[0] ? IDX_W'(MAX_BYTES - 1) : IDX_W'(MAX_BYTES - 2);

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st   = ST_FETCH;
                    r_d.mode = ipf_mode_e'(mode_i);
                    r_d.ptr  = base_ptr;
                    r_d.idx  = '0;
                    r_d.bank = dbank_i;
                end
            end
            ST_FETCH: begin
                if (rd_valid_i) begin
                    for (int i = 0; i < MAX_BYTES; i++) begin
                        if (r_q.idx == IDX_W'(i)) r_d.bytes[i] = rd_data_i;
                    end
                    if (r_q.idx == last_idx) r_d.st  = ST_DONE;
                    else                     r_d.idx = r_q.idx + 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign busy_o    = (r_q.st != ST_IDLE);
    assign rd_req_o  = (r_q.st == ST_FETCH);
    assign rd_addr_o = {{BYTE_W{1'b0}}, r_q.ptr + PTR_W'(r_q.idx)};
    assign done_o    = (r_q.st == ST_DONE);
    assign ea_load_o = done_o &  r_q.mode[1];
    assign pc_load_o = done_o & ~r_q.mode[1];
    assign pb_load_o = done_o &  (r_q.mode == IPF_JMP_LONG);

    ipf_assemble #(.BYTE_W(BYTE_W), .MAX_BYTES(MAX_BYTES)) u_asm (
        .long_sel (r_q.mode[0]),
        .bytes    (r_q.bytes),
        .bank     (r_q.bank),
        .ea       (ea_o),
        .pc       (pc_o),
        .pb       (pb_o)
    );

    // R6
    rd_bank_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req_o |-> (rd_addr_o[EA_W-1:PTR_W] == '0));

    // R7
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req_o && !rd_valid_i) |=> (rd_req_o && $stable(rd_addr_o)));

    // R7
    rd_step_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req_o && rd_valid_i) |=> (!rd_req_o ||
            rd_addr_o[PTR_W-1:0] == PTR_W'($past(rd_addr_o[PTR_W-1:0]) + 1'b1)));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R8
    one_result_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $onehot({ea_load_o, pc_load_o}));

    // R8
    strobe_gated_chk: assert property (@(posedge clk) disable iff (rst)
        (ea_load_o || pc_load_o || pb_load_o) |-> done_o);

    // R3
    bank_with_pc_chk: assert property (@(posedge clk) disable iff (rst)
        pb_load_o |-> pc_load_o);

    // R9
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        (start && rd_req_o && !rd_valid_i) |=> $stable(rd_addr_o));
endmodule

// File: tb/tb_ind_ptr_fetch.sv
`timescale 1ns/1ps
module tb_ind_ptr_fetch;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  mode_i = 2'b00;
    logic [7:0]  op_lo_i = '0, op_hi_i = '0, dbank_i = '0;
    logic [15:0] dir_reg_i = '0;
    logic        rd_req_o, rd_valid_i = 1'b0;
    logic [23:0] rd_addr_o;
    logic [7:0]  rd_data_i = '0;
    logic [23:0] ea_o;
    logic [15:0] pc_o;
    logic [7:0]  pb_o;
    logic        ea_load_o, pc_load_o, pb_load_o, done_o, busy_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int lat    = 0;
    int wcnt   = 0;

    always #4 clk = ~clk;

    ind_ptr_fetch dut (
        .clk(clk), .rst(rst), .start(start), .mode_i(mode_i),
        .op_lo_i(op_lo_i), .op_hi_i(op_hi_i), .dir_reg_i(dir_reg_i), .dbank_i(dbank_i),
        .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i),
        .ea_o(ea_o), .ea_load_o(ea_load_o), .pc_o(pc_o), .pc_load_o(pc_load_o),
        .pb_o(pb_o), .pb_load_o(pb_load_o), .done_o(done_o), .busy_o(busy_o)
    );

    function automatic logic [7:0] mem_f(input logic [15:0] a);
        return a[7:0] ^ {a[12:8], a[15:13]} ^ 8'h5A;
    endfunction

    function automatic logic [15:0] exp_ptr(input logic [1:0] m, input logic [7:0] lo, hi,
                                            input logic [15:0] dr);
        return m[1] ? 16'(dr + {8'h00, lo}) : {hi, lo};
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Memory model: answers after `lat` waiting cycles, one byte per valid.
    always @(negedge clk) begin
        if (rd_req_o) begin
            if (wcnt >= lat) begin
                rd_valid_i = 1'b1;
                rd_data_i  = mem_f(rd_addr_o[15:0]);
                wcnt       = 0;
            end else begin
                rd_valid_i = 1'b0;
                wcnt       = wcnt + 1;
            end
        end else begin
            rd_valid_i = 1'b0;
            wcnt       = 0;
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            checks++;
            fails++;
            $display("FAIL R8 watchdog: actual cycles %0d expected < %0d", cyc, 150000);
            summary();
            $finish;
        end
    end

    task automatic run_op(input logic [1:0] m, input logic [7:0] lo, hi, input logic [15:0] dr,
                          input logic [7:0] db, input int l, input bit perturb);
        logic [15:0] p;
        logic [7:0]  b [3];
        logic [23:0] got [4];
        int          nb, ng;
        bit          prev_v, seen;
        p  = exp_ptr(m, lo, hi, dr);
        nb = m[0] ? 3 : 2;
        for (int i = 0; i < 3; i++) b[i] = mem_f(16'(p + 16'(i)));
        lat = l;
        mode_i = m; op_lo_i = lo; op_hi_i = hi; dir_reg_i = dr; dbank_i = db;
        start = 1'b1;
        @(negedge clk); #1;
        start = 1'b0;
        ng = 0; prev_v = 1'b0; seen = 1'b0;
        for (int k = 0; k < 80 && !seen; k++) begin
            if (done_o) begin
                seen = 1'b1;
            end else begin
                if (ea_load_o || pc_load_o || pb_load_o)
                    chk(1'b0, "R8", "strobe before done", 1, 0);
                if (rd_valid_i && rd_req_o) begin
                    if (ng < 4) got[ng] = rd_addr_o;
                    ng++;
                end
                prev_v = rd_valid_i && rd_req_o;
                if (perturb && k == 2) begin
                    // R9 R10: restart attempt with every input changed
                    start = 1'b1; mode_i = ~m; op_lo_i = ~lo; op_hi_i = ~hi;
                    dir_reg_i = ~dr; dbank_i = ~db;
                end else begin
                    start = 1'b0;
                end
                @(negedge clk); #1;
            end
        end
        start = 1'b0;
        chk(seen, "R8", "done seen", 32'(seen), 1);
        chk(prev_v, "R8", "done one cycle after last byte", 32'(prev_v), 1);
        chk(ng == nb, "R7", "bytes accepted", 32'(ng), 32'(nb));
        for (int i = 0; i < 3; i++) begin
            if (i < nb && i < ng)
                chk(got[i] == {8'h00, 16'(p + 16'(i))}, "R7", "read address order (R6 wrap)",
                    32'(got[i]), {8'h00, 8'h00, 16'(p + 16'(i))});
        end
        chk(ea_load_o == m[1], "R8", "ea_load", 32'(ea_load_o), 32'(m[1]));
        chk(pc_load_o == !m[1], "R8", "pc_load", 32'(pc_load_o), 32'(!m[1]));
        case (m)
            2'b00: begin
                chk(pc_o == {b[1], b[0]}, "R2", "pc", 32'(pc_o), 32'({b[1], b[0]}));
                chk(!pb_load_o, "R2", "pb_load low", 32'(pb_load_o), 0);
            end
            2'b01: begin
                chk(pc_o == {b[1], b[0]}, "R3", "pc", 32'(pc_o), 32'({b[1], b[0]}));
                chk(pb_load_o && pb_o == b[2], "R3", "bank", {23'd0, pb_load_o, pb_o}, {24'd1, b[2]});
            end
            2'b10: begin
                chk(ea_o == {db, b[1], b[0]} && !pb_load_o, "R4", "ea", 32'(ea_o), 32'({db, b[1], b[0]}));
                if (perturb) chk(ea_o == {db, b[1], b[0]}, "R10", "sampled inputs", 32'(ea_o), 32'({db, b[1], b[0]}));
            end
            default: begin
                chk(ea_o == {b[2], b[1], b[0]} && !pb_load_o, "R5", "ea", 32'(ea_o), 32'({b[2], b[1], b[0]}));
                if (perturb) chk(ea_o == {b[2], b[1], b[0]}, "R9", "busy start ignored", 32'(ea_o), 32'({b[2], b[1], b[0]}));
            end
        endcase
        @(negedge clk); #1;
        chk(!done_o && !busy_o && !ea_load_o && !pc_load_o, "R8", "single-cycle done",
            {30'd0, done_o, busy_o}, 0);
    endtask

    typedef struct packed {
        logic [1:0]  m;
        logic [7:0]  lo;
        logic [7:0]  hi;
        logic [15:0] dr;
        logic [7:0]  db;
        logic [1:0]  l;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{2'b00, 8'h34, 8'h12, 16'h0000, 8'h00, 2'd0},  // R2
        '{2'b00, 8'hFF, 8'hFF, 16'h0000, 8'h00, 2'd1},  // R2 R6
        '{2'b01, 8'h00, 8'h80, 16'h0000, 8'h00, 2'd0},  // R3
        '{2'b01, 8'hFE, 8'hFF, 16'h0000, 8'h00, 2'd2},  // R3 R6
        '{2'b10, 8'h05, 8'h00, 16'h1200, 8'h7E, 2'd0},  // R4
        '{2'b10, 8'h20, 8'h00, 16'hFFF0, 8'h01, 2'd1},  // R4 R6
        '{2'b11, 8'h80, 8'h00, 16'h0300, 8'hAA, 2'd0},  // R5
        '{2'b11, 8'h0F, 8'h00, 16'hFFFE, 8'h55, 2'd2}   // R5 R6
    };

    initial begin
        repeat (3) @(negedge clk);
        #1;
        rst = 1'b0;
        // R1: state after reset
        chk(!busy_o && !rd_req_o && !done_o && !ea_load_o && !pc_load_o && !pb_load_o,
            "R1", "idle after reset", {27'd0, busy_o, rd_req_o, done_o, ea_load_o, pc_load_o}, 0);

        foreach (VEC[i]) run_op(VEC[i].m, VEC[i].lo, VEC[i].hi, VEC[i].dr, VEC[i].db, int'(VEC[i].l), 1'b0);

        // R9 R10: start while busy, all inputs changed afterwards
        run_op(2'b11, 8'h44, 8'h00, 16'h2000, 8'h3C, 2, 1'b1);
        run_op(2'b10, 8'h10, 8'h00, 16'h4000, 8'hC3, 2, 1'b1);

        // R1: reset in the middle of a fetch
        lat = 2;
        mode_i = 2'b01; op_lo_i = 8'h00; op_hi_i = 8'h20;
        start = 1'b1;
        @(negedge clk); #1;
        start = 1'b0;
        @(negedge clk); #1;
        chk(busy_o, "R1", "busy before mid reset", 32'(busy_o), 1);
        rst = 1'b1;
        @(negedge clk); #1;
        rst = 1'b0;
        chk(!busy_o && !rd_req_o && !done_o && !pc_load_o && !pb_load_o && !ea_load_o,
            "R1", "idle after mid reset", {28'd0, busy_o, rd_req_o, done_o, pc_load_o}, 0);
        run_op(2'b01, 8'h10, 8'h20, 16'h0000, 8'h00, 0, 1'b0);

        summary();
        $finish;
    end
endmodule